// File: doc/BRIEF.md
# Three-Phase Carrier PWM Generator

This block drives the three half-bridge command signals of a motor inverter from one shared counter. The counter counts in one of two ways. In sawtooth mode it runs up to the period value and then restarts at zero. In triangle mode it runs up to the period value and then back down to zero. Each of the three phases compares the counter with its own compare value and produces one PWM output. In triangle mode the three pulses stay centred on the same point of the carrier, which is the timing that symmetrical space-vector schemes rely on.

Software writes new period and compare values into holding registers at any time. These values reach the comparators only at a carrier wrap point, and only after a programmable number of wrap points has gone by. The new duty cycles therefore never land part-way through a pulse. A one-clock pulse marks each transfer, so firmware can time its next calculation to it. A clock divider slows the counter so that long carrier periods can be reached.

Top module: `pwm3_gen`

## Requirements
- R1: A write takes place on a clock edge where `wr_en` is high. Address 0 is the control word: bit 0 run, bit 1 triangle mode, bit 2 update-pulse enable, bits 6:4 divider select `d`. Address 1 holds the pending period (12 bits). Addresses 2, 3 and 4 hold the pending compares for U, V and W (13 bits each). Address 5 holds the repetition count (8 bits). The control word and the repetition count take effect at once.
- R2: The counter advances once every `d+1` clocks. In sawtooth mode one carrier period lasts `(P+1)*(d+1)` clocks, where P is the active period.
- R3: In sawtooth mode the counter steps 0, 1, …, P and then returns to 0. A phase output is high while the counter is below its compare C, so it is high for `min(C, P+1)` counter steps in each period.
- R4: In triangle mode (P>0) one period has `2P` counter steps: P steps counting up and P steps counting down. On the way up an output falls when the counter reaches C. On the way down it rises when the counter reaches C. A phase with C≥1 is high for `min(P, C-1) + min(P, C+1)` steps of each period.
- R5: A compare of 0 holds the phase output low. A compare above P, including values of 4096 and above, holds it high for the whole period.
- R6: Pending period and compare values reach the counter logic only at a wrap event, and only when the repetition countdown is zero. Before that, the output keeps the previous duty cycle.
- R7: Each wrap event decrements the repetition countdown. In sawtooth mode the wrap event is the return to 0. In triangle mode both the top and the bottom are wrap events. When a transfer happens, the countdown reloads from the repetition count N. Transfers therefore happen every N+1 wrap events, which in triangle mode with N=2 is every 1.5 periods.
- R8: `upd_evt` is high for the one clock after each transfer when update pulses are enabled. It stays low when they are disabled.
- R9: After reset all outputs are 0, and the counter, divider, repetition countdown and active values are cleared. While run is clear the counter holds, and neither the outputs nor `upd_evt` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_u | output | 1 | Phase U PWM output |
| pwm_v | output | 1 | Phase V PWM output |
| pwm_w | output | 1 | Phase W PWM output |
| upd_evt | output | 1 | One-clock pulse after a transfer of the pending values |

## Verification
The directed patterns cover the two counting modes and the extreme compare values. Compares of 0, of exactly P+1 and above 4096 separate the forced-low and forced-high edges from the ordinary comparison. A triangle case with repetition 2 shows whether both the top and the bottom of the carrier are counted as wrap events. Another case changes a compare between two transfers, to separate "held until transfer" from "applied at once". Random configurations then vary the mode, divider, period, compares and repetition count. Each case is checked by counting high clocks over whole periods and by measuring the spacing of update pulses against closed-form expressions.

// File: rtl/pwm3_gen.sv
module pwm3_gen #(
  parameter int CW = 12,
  parameter int PW = CW + 1,
  parameter int RW = 8,
  parameter int SW = 3,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_u,
  output logic          pwm_v,
  output logic          pwm_w,
  output logic          upd_evt
);
  localparam logic [AW-1:0] A_CTRL = 0, A_PER = 1, A_CU = 2, A_CV = 3, A_CW = 4, A_REP = 5;
  localparam logic [CW-1:0] CNT_ONE = 1;
  localparam logic [SW-1:0] DIV_ONE = 1;
  localparam logic [RW-1:0] REP_ONE = 1;

  logic          run, center, upd_en;
  logic [SW-1:0] psc, psc_cnt;
  logic [CW-1:0] per_pre, per_act, cnt;
  logic [PW-1:0] cmp_pre [3];
  logic [PW-1:0] cmp_act [3];
  logic [RW-1:0] rep_reg, rep_cnt;
  logic          dir_up;
  logic [2:0]    hi_v, pwm_q;
  logic          upd_q;
  logic          tick, wrap, xfer;
  logic [PW-1:0] cnt_x;
  logic          unused_bits;

  assign unused_bits = ^wr_data[DW-1:PW];

  assign tick  = run && (psc_cnt >= psc);
  assign wrap  = tick && ((center && !dir_up) ? (cnt == '0) : (cnt >= per_act));
  assign xfer  = wrap && (rep_cnt == '0);
  assign cnt_x = PW'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; center <= 1'b0; upd_en <= 1'b0; psc <= '0;
      per_pre <= '0; rep_reg <= '0;
      cmp_pre[0] <= '0; cmp_pre[1] <= '0; cmp_pre[2] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run    <= wr_data[0];
          center <= wr_data[1];
          upd_en <= wr_data[2];
          psc    <= wr_data[4 +: SW];
        end
        A_PER:  per_pre    <= wr_data[CW-1:0];
        A_CU:   cmp_pre[0] <= wr_data[PW-1:0];
        A_CV:   cmp_pre[1] <= wr_data[PW-1:0];
        A_CW:   cmp_pre[2] <= wr_data[PW-1:0];
        A_REP:  rep_reg    <= wr_data[RW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    psc_cnt <= '0;
    else if (tick) psc_cnt <= '0;
    else if (run)  psc_cnt <= psc_cnt + DIV_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      if (!center) begin
        dir_up <= 1'b1;
        cnt    <= wrap ? '0 : cnt + CNT_ONE;
      end else if (dir_up) begin
        if (wrap) begin
          dir_up <= 1'b0;
          if (cnt != '0) cnt <= cnt - CNT_ONE;
        end else begin
          cnt <= cnt + CNT_ONE;
        end
      end else begin
        if (wrap) begin
          dir_up <= 1'b1;
          if (per_act != '0) cnt <= CNT_ONE;
        end else begin
          cnt <= cnt - CNT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_cnt <= '0;
      per_act <= '0;
      cmp_act[0] <= '0; cmp_act[1] <= '0; cmp_act[2] <= '0;
    end else if (wrap) begin
      if (rep_cnt == '0) begin
        rep_cnt    <= rep_reg;
        per_act    <= per_pre;
        cmp_act[0] <= cmp_pre[0];
        cmp_act[1] <= cmp_pre[1];
        cmp_act[2] <= cmp_pre[2];
      end else begin
        rep_cnt <= rep_cnt - REP_ONE;
      end
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_ph
    assign hi_v[i] = (cmp_act[i] != '0) &&
                     ((center && !dir_up) ? (cnt_x <= cmp_act[i]) : (cnt_x < cmp_act[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= '0;
      upd_q <= 1'b0;
    end else begin
      pwm_q <= hi_v;
      upd_q <= xfer && upd_en;
    end
  end

  assign pwm_u   = pwm_q[0];
  assign pwm_v   = pwm_q[1];
  assign pwm_w   = pwm_q[2];
  assign upd_evt = upd_q;

  a_r2_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0 && !wr_en) |=> !tick);
  a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !center) |=> (cnt == '0));
  a_r4_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && center && dir_up) |=> !dir_up);
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act[0] == '0) |=> !pwm_u);
  a_r6_xfer_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_act) || !$stable(cmp_act[1])) |-> $past(wrap && rep_cnt == '0));
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && rep_cnt != '0) |=> (rep_cnt == $past(rep_cnt) - REP_ONE));
  a_r8_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> $past(upd_en));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: tb/pwm3_gen_test.sv
`timescale 1ns/1ps
module pwm3_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_u, pwm_v, pwm_w, upd_evt;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwm3_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w), .upd_evt(upd_evt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_upd(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!upd_evt && waited < 20000);
  endtask

  task automatic meas(int n, output int hu, output int hv, output int hw, output int hp);
    hu = 0; hv = 0; hw = 0; hp = 0;
    repeat (n) begin
      @(negedge clk);
      hu += int'(pwm_u); hv += int'(pwm_v); hw += int'(pwm_w); hp += int'(upd_evt);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int hi_ticks(bit ctr, int per, int cmp);
    if (!ctr) return imin(cmp, per + 1);
    if (cmp == 0) return 0;
    return imin(per, cmp - 1) + imin(per, cmp + 1);
  endfunction

  function automatic int per_ticks(bit ctr, int per);
    return ctr ? 2 * per : per + 1;
  endfunction

  function automatic int ev_ticks(bit ctr, int per);
    return ctr ? per : per + 1;
  endfunction

  function automatic int ctrl_word(bit run, bit ctr, bit ien, int psc);
    return int'(run) | (int'(ctr) << 1) | (int'(ien) << 2) | (psc << 4);
  endfunction

  task automatic cfg(bit ctr, int psc, int per, int cu, int cv, int cw, int rep);
    do_reset();
    wr(1, per); wr(2, cu); wr(3, cv); wr(4, cw); wr(5, rep);
    wr(0, ctrl_word(1'b1, ctr, 1'b1, psc));
  endtask

  task automatic run_case(string tag, bit ctr, int psc, int per, int cu, int cv, int cw, int rep);
    int w, hu, hv, hw, hp, n;
    cfg(ctr, psc, per, cu, cv, cw, rep);
    wait_upd(w); wait_upd(w); wait_upd(w);
    chk({tag, " R7 R2 update spacing"}, w, (rep + 1) * ev_ticks(ctr, per) * (psc + 1));
    n = 2 * per_ticks(ctr, per) * (psc + 1);
    meas(n, hu, hv, hw, hp);
    chk({tag, ctr ? " R4" : " R3", " R5 high clocks U"}, hu, 2 * hi_ticks(ctr, per, cu) * (psc + 1));
    chk({tag, ctr ? " R4" : " R3", " R5 high clocks V"}, hv, 2 * hi_ticks(ctr, per, cv) * (psc + 1));
    chk({tag, ctr ? " R4" : " R3", " R5 high clocks W"}, hw, 2 * hi_ticks(ctr, per, cw) * (psc + 1));
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w, hu, hv, hw, hp;
    int unsigned seed;
    do_reset();
    @(negedge clk);
    chk("R9 reset pwm_u", int'(pwm_u), 0);
    chk("R9 reset pwm_v", int'(pwm_v), 0);
    chk("R9 reset pwm_w", int'(pwm_w), 0);
    chk("R9 reset upd_evt", int'(upd_evt), 0);

    // R1 R9: registers written with run clear, counter must stay idle
    wr(1, 9); wr(2, 3); wr(3, 5); wr(4, 7); wr(5, 0);
    wr(0, ctrl_word(1'b0, 1'b0, 1'b1, 0));
    meas(200, hu, hv, hw, hp);
    chk("R9 idle outputs", hu + hv + hw, 0);
    chk("R9 idle no update pulse", hp, 0);

    run_case("R1 edge basic", 1'b0, 0, 9, 3, 5, 7, 0);
    run_case("R2 edge divided", 1'b0, 3, 9, 0, 4096, 10, 2);
    run_case("R4 center rep2", 1'b1, 0, 8, 4, 0, 9, 2);
    run_case("R4 center divided", 1'b1, 2, 6, 1, 6, 7, 1);

    // R6: compare written between transfers keeps old duty until the next transfer
    cfg(1'b0, 0, 9, 2, 5, 5, 4);
    wait_upd(w); wait_upd(w);
    wr(2, 8);
    meas(30, hu, hv, hw, hp);
    chk("R6 old duty held before transfer", hu, 6);
    chk("R6 no transfer inside window", hp, 0);
    wait_upd(w);
    repeat (3) @(negedge clk);
    meas(30, hu, hv, hw, hp);
    chk("R6 new duty after transfer", hu, 24);
    chk("R6 other phase unchanged", hv, 15);

    // R8: pulse disabled
    wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 0));
    meas(200, hu, hv, hw, hp);
    chk("R8 no pulse when disabled", hp, 0);
    chk("R8 outputs keep running", hu, 160);

    seed = $urandom(32'd918273);
    for (int i = 0; i < 10; i++) begin
      bit ctr;
      int psc, per, cu, cv, cw, rep;
      ctr = 1'($urandom_range(1, 0));
      psc = int'($urandom_range(7, 0));
      per = int'($urandom_range(30, 3));
      cu  = int'($urandom_range(per + 2, 0));
      cv  = int'($urandom_range(per + 2, 0));
      cw  = int'($urandom_range(per + 2, 0));
      rep = int'($urandom_range(3, 0));
      run_case("random", ctr, psc, per, cu, cv, cw, rep);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule